// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Five Status Flags

This block performs one 8-bit arithmetic, logical or rotate operation per accepted request. The two data operands are the accumulator value and a second operand. The carry that goes in is read from bit 0 of the current flag byte, which the caller supplies on `flagIn`. The block returns three things: the 8-bit result, a write strobe for the accumulator, and the new flag byte. The new flag byte is built from `flagIn`. Each operation class rewrites its own subset of the five live flags and passes the other flags through unchanged.

All outputs are registered. They appear one clock after a request is accepted. The caller is expected to write `flagOut` back into its flag register and to offer it again as `flagIn` on the next operation.

Top module: `alu8_flags`

## Requirements
- R1: When `opValid` is high at a rising edge, `resOut`, `accWe` and `flagOut` show that operation's outcome after that edge. `accWe` is high for exactly that one cycle, and only for codes 0..3 and 5..13. After an edge with `opValid` low, `accWe` is 0 and `resOut` and `flagOut` keep their values.
- R2: The `opSel` codes are:
  - 0 add, result a+b
  - 1 add with carry, result a+b+CY
  - 5 increment, result a+1
  - 6 decrement, result a-1

  All of these results are modulo 256. For codes 0 and 1, CY is the carry out of bit 7.
- R3: The subtract codes are:
  - 2 subtract, result a-b
  - 3 subtract with borrow, result a-b-CY

  Both results are modulo 256. CY becomes 1 exactly when a borrow occurs, that is, when the unsigned minuend is less than the unsigned subtrahend (including the CY term for code 3).
- R4: For every code in 0..9, S (bit 7) equals bit 7 of the result, and Z (bit 6) is 1 exactly when the result is zero.
- R5: For every code in 0..9, P (bit 2) is 1 exactly when the result has an even number of one bits.
- R6: AC (bit 4) is the carry out of bit 3 of the internal two's-complement adder:
  - for add: from a+b+cin
  - for subtract: from a+~b+(1-borrow in)
  - for increment: set when a[3:0]=F
  - for decrement: set when a[3:0]≠0
- R7: Code 4 (compare) sets all five flags exactly as subtract would. It never raises `accWe`.
- R8: Increment and decrement rewrite S, Z, AC and P. CY is copied unchanged from `flagIn`.
- R9: The logical codes are 7 AND, 8 OR and 9 XOR. Each gives the bitwise result and clears both CY and AC.
- R10: The rotate codes are 10, 11, 12 and 13. They change only CY; S, Z, AC and P are copied from `flagIn`. The four rotates are:
  - 10 rotates left, with bit 7 going to bit 0 and to CY
  - 11 rotates right, with bit 0 going to bit 7 and to CY
  - 12 rotates left through carry, with the old CY entering bit 0 and bit 7 going to CY
  - 13 rotates right through carry, with the old CY entering bit 7 and bit 0 going to CY
- R11: In `flagOut`, bits 5 and 3 are always 0 and bit 1 is always 1. After reset, `flagOut`=0x02, `resOut`=0 and `accWe`=0.
- R12: Codes 14 and 15 do not write the accumulator. For these codes, `flagOut` equals `flagIn` with the constant bits forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Accept an operation this cycle |
| opSel | input | 4 | Operation code |
| accIn | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| flagIn | input | 8 | Current flag byte; bit 0 is carry in |
| resOut | output | 8 | Registered result |
| accWe | output | 1 | Accumulator write strobe |
| flagOut | output | 8 | Registered updated flag byte |

## Verification
The bench aims at the nibble and byte boundaries. These include 0x0F+0x01, 0xFF+0x01, 0x00-0x01, and subtract with borrow where the borrow alone underflows. In these cases a wrong adder carry or an inverted borrow polarity shows up as a wrong CY or AC. Compare with equal operands must set Z while holding `accWe` low; a design that wrote back on compare would corrupt the accumulator. The bench runs increment and decrement with CY both set and clear, and rotates through carry with both values of old CY. This catches a design that disturbs CY on increment and decrement, or that drops the old carry on a rotate. Idle cycles confirm that the outputs hold and the write strobe stays low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int NIB = DW / 2;
  localparam int F_S = 7;
  localparam int F_Z = 6;
  localparam int F_AC = 4;
  localparam int F_P = 2;
  localparam int F_CY = 0;
  localparam logic [DW-1:0] FLAG_ONES_MASK = 8'h02;
  localparam logic [DW-1:0] FLAG_LIVE_MASK = 8'hD5;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_CMP = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_AND = 4'd7,
    OP_OR  = 4'd8, OP_XOR = 4'd9, OP_RLC = 4'd10, OP_RRC = 4'd11,
    OP_RAL = 4'd12, OP_RAR = 4'd13, OP_NOPA = 4'd14, OP_NOPB = 4'd15
  } aluOpE;

  typedef struct packed {
    logic       invB;
    logic       useCin;
    logic       oneB;
    logic [1:0] logKind;
    logic       rotEn;
    logic [1:0] rotKind;
    logic       wrAcc;
    logic       updSzp;
    logic       updCy;
  } aluStrobeT;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0] opSel,
  output aluStrobeT  stb
);
  always_comb begin
    stb = '0;
    case (aluOpE'(opSel))
      OP_ADD: begin stb.updSzp = 1'b1; stb.updCy = 1'b1; stb.wrAcc = 1'b1; end
      OP_ADC: begin stb.updSzp = 1'b1; stb.updCy = 1'b1; stb.wrAcc = 1'b1; stb.useCin = 1'b1; end
      OP_SUB: begin stb.updSzp = 1'b1; stb.updCy = 1'b1; stb.wrAcc = 1'b1; stb.invB = 1'b1; end
      OP_SBB: begin stb.updSzp = 1'b1; stb.updCy = 1'b1; stb.wrAcc = 1'b1; stb.invB = 1'b1;
                    stb.useCin = 1'b1; end
      OP_CMP: begin stb.updSzp = 1'b1; stb.updCy = 1'b1; stb.invB = 1'b1; end
      OP_INC: begin stb.updSzp = 1'b1; stb.wrAcc = 1'b1; stb.oneB = 1'b1; end
      OP_DEC: begin stb.updSzp = 1'b1; stb.wrAcc = 1'b1; stb.oneB = 1'b1; stb.invB = 1'b1; end
      OP_AND: begin stb.updSzp = 1'b1; stb.updCy = 1'b1; stb.wrAcc = 1'b1; stb.logKind = 2'd1; end
      OP_OR:  begin stb.updSzp = 1'b1; stb.updCy = 1'b1; stb.wrAcc = 1'b1; stb.logKind = 2'd2; end
      OP_XOR: begin stb.updSzp = 1'b1; stb.updCy = 1'b1; stb.wrAcc = 1'b1; stb.logKind = 2'd3; end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        stb.rotEn   = 1'b1;
        stb.rotKind = opSel[1:0] + 2'd2;
        stb.updCy   = 1'b1;
        stb.wrAcc   = 1'b1;
      end
      default: stb = '0;
    endcase
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
(
  input  aluStrobeT      stb,
  input  logic [DW-1:0]  aIn,
  input  logic [DW-1:0]  bIn,
  input  logic [DW-1:0]  fIn,
  output logic [DW-1:0]  res,
  output logic [DW-1:0]  fOut
);
  logic [DW-1:0]  bX;
  logic           cinBit;
  logic [DW:0]    sum;
  logic [NIB:0]   nibSum;
  logic           arithCy;
  logic [DW-1:0]  rotRes;
  logic           rotCy;
  logic           isLogic;
  logic           unusedFlagBits;

  assign unusedFlagBits = ^{fIn[5], fIn[3], fIn[1]};

  always_comb begin
    bX = stb.oneB ? {{(DW-1){1'b0}}, 1'b1} : bIn;
    if (stb.invB) bX = ~bX;
    if (stb.invB) cinBit = stb.useCin ? ~fIn[F_CY] : 1'b1;
    else          cinBit = stb.useCin ?  fIn[F_CY] : 1'b0;
    sum     = {1'b0, aIn} + {1'b0, bX} + {{DW{1'b0}}, cinBit};
    nibSum  = {1'b0, aIn[NIB-1:0]} + {1'b0, bX[NIB-1:0]} + {{NIB{1'b0}}, cinBit};
    arithCy = stb.invB ? ~sum[DW] : sum[DW];
  end

  always_comb begin
    case (stb.rotKind)
      2'd0:    begin rotRes = {aIn[DW-2:0], aIn[DW-1]};   rotCy = aIn[DW-1]; end
      2'd1:    begin rotRes = {aIn[0], aIn[DW-1:1]};      rotCy = aIn[0];    end
      2'd2:    begin rotRes = {aIn[DW-2:0], fIn[F_CY]};   rotCy = aIn[DW-1]; end
      default: begin rotRes = {fIn[F_CY], aIn[DW-1:1]};   rotCy = aIn[0];    end
    endcase
  end

  assign isLogic = (stb.logKind != 2'd0);

  always_comb begin
    if (stb.rotEn) res = rotRes;
    else begin
      case (stb.logKind)
        2'd1:    res = aIn & bIn;
        2'd2:    res = aIn | bIn;
        2'd3:    res = aIn ^ bIn;
        default: res = sum[DW-1:0];
      endcase
    end
  end

  always_comb begin
    fOut = fIn;
    if (stb.updSzp) begin
      fOut[F_S]  = res[DW-1];
      fOut[F_Z]  = (res == '0);
      fOut[F_P]  = ~^res;
      fOut[F_AC] = isLogic ? 1'b0 : nibSum[NIB];
    end
    if (stb.updCy)
      fOut[F_CY] = stb.rotEn ? rotCy : (isLogic ? 1'b0 : arithCy);
    fOut = (fOut & FLAG_LIVE_MASK) | FLAG_ONES_MASK;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opSel,
  input  logic [7:0] accIn,
  input  logic [7:0] opnd,
  input  logic [7:0] flagIn,
  output logic [7:0] resOut,
  output logic       accWe,
  output logic [7:0] flagOut
);
  aluStrobeT     stb;
  logic [DW-1:0] resNext;
  logic [DW-1:0] flagNext;

  alu8_ctrl u_ctrl (.opSel(opSel), .stb(stb));

  alu8_datapath u_dp (
    .stb(stb), .aIn(accIn), .bIn(opnd), .fIn(flagIn),
    .res(resNext), .fOut(flagNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOut  <= '0;
      accWe   <= 1'b0;
      flagOut <= FLAG_ONES_MASK;
    end else begin
      accWe <= opValid & stb.wrAcc;
      if (opValid) begin
        resOut  <= resNext;
        flagOut <= flagNext;
      end
    end
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [3:0] opSel,
  input logic [7:0] flagIn,
  input logic [7:0] resOut,
  input logic       accWe,
  input logic [7:0] flagOut
);
  a_r11_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    (flagOut[5] == 1'b0) && (flagOut[3] == 1'b0) && (flagOut[1] == 1'b1));

  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !accWe);

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(resOut) && $stable(flagOut));

  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 4'd4) |=> !accWe);

  a_r8_incdec_keep_cy: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == 4'd5 || opSel == 4'd6)) |=> flagOut[0] == $past(flagIn[0]));

  a_r9_logic_clear: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel >= 4'd7 && opSel <= 4'd9) |=> (flagOut[0] == 1'b0) && (flagOut[4] == 1'b0));

  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel <= 4'd9) |=> flagOut[6] == (resOut == 8'h00));

  a_r5_parity_flag: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel <= 4'd9) |=> flagOut[2] == ~^resOut);

  a_r10_rot_only_cy: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel >= 4'd10 && opSel <= 4'd13) |=>
      ({flagOut[7:6], flagOut[4], flagOut[2]} ==
       $past({flagIn[7:6], flagIn[4], flagIn[2]})));

  a_r12_unused_code: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel >= 4'd14) |=> !accWe && ((flagOut & 8'hD5) == ($past(flagIn) & 8'hD5)));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .flagIn(flagIn),
  .resOut(resOut), .accWe(accWe), .flagOut(flagOut)
);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] accIn = '0;
  logic [7:0] opnd = '0;
  logic [7:0] flagIn = '0;
  logic [7:0] resOut;
  logic       accWe;
  logic [7:0] flagOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu8_flags dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .accIn(accIn),
    .opnd(opnd), .flagIn(flagIn), .resOut(resOut), .accWe(accWe), .flagOut(flagOut)
  );

  function automatic string reqOf(input int op);
    if (op <= 1) return "R2";
    if (op <= 3) return "R3";
    if (op == 4) return "R7";
    if (op <= 6) return "R8";
    if (op <= 9) return "R9";
    if (op <= 13) return "R10";
    return "R12";
  endfunction

  // returns {we, result, flags}
  function automatic logic [16:0] model(input int op, input int a, input int b, input logic [7:0] f);
    int r; int cy; int ac; int w; logic [7:0] nf; int ci; int ones;
    ci = f[0]; nf = f; r = a; w = 1; cy = ci; ac = f[4];
    case (op)
      0: begin r = a + b; cy = (r > 255); ac = ((a % 16) + (b % 16)) > 15; end
      1: begin r = a + b + ci; cy = (r > 255); ac = ((a % 16) + (b % 16) + ci) > 15; end
      2, 4: begin r = a - b; cy = (a < b); ac = ((a % 16) + (15 - (b % 16)) + 1) > 15; end
      3: begin r = a - b - ci; cy = (a < b + ci); ac = ((a % 16) + (15 - (b % 16)) + 1 - ci) > 15; end
      5: begin r = a + 1; ac = ((a % 16) == 15); end
      6: begin r = a - 1; ac = ((a % 16) != 0); end
      7: begin r = a & b; cy = 0; ac = 0; end
      8: begin r = a | b; cy = 0; ac = 0; end
      9: begin r = a ^ b; cy = 0; ac = 0; end
      10: begin r = ((a * 2) % 256) + (a / 128); cy = a / 128; end
      11: begin r = (a / 2) + (a % 2) * 128; cy = a % 2; end
      12: begin r = ((a * 2) % 256) + ci; cy = a / 128; end
      13: begin r = (a / 2) + ci * 128; cy = a % 2; end
      default: begin w = 0; end
    endcase
    r = r & 255;
    if (op == 4) w = 0;
    if (op <= 9) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      nf[7] = r[7]; nf[6] = (r == 0); nf[2] = (ones % 2 == 0); nf[4] = ac[0];
    end
    if (op <= 4 || (op >= 7 && op <= 13)) nf[0] = cy[0];
    nf[5] = 0; nf[3] = 0; nf[1] = 1;
    return {w[0], r[7:0], nf};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [7:0] lastRes;
  logic [7:0] lastFlg;

  task automatic runOp(input int op, input int a, input int b, input logic [7:0] f);
    logic [16:0] e;
    e = model(op, a, b, f);
    opValid = 1'b1; opSel = op[3:0]; accIn = a[7:0]; opnd = b[7:0]; flagIn = f;
    @(negedge clk);
    opValid = 1'b0;
    check(reqOf(op), "we", accWe, e[16]);
    check(op <= 9 ? "R4" : reqOf(op), "flags", flagOut, e[7:0]);
    if (e[16]) check(reqOf(op), "result", resOut, e[15:8]);
    lastRes = resOut; lastFlg = flagOut;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "reset flags", flagOut, 8'h02);
    check("R11", "reset result", resOut, 0);
    check("R1", "reset we", accWe, 0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corner cases
    runOp(0, 8'h0F, 8'h01, 8'h00);  // R6 half carry
    runOp(0, 8'hFF, 8'h01, 8'h00);  // R2 carry, zero
    runOp(2, 8'h00, 8'h01, 8'h00);  // R3 borrow
    runOp(2, 8'h10, 8'h01, 8'h00);  // R6 sub nibble
    runOp(3, 8'h00, 8'h00, 8'h01);  // R3 borrow alone
    runOp(1, 8'h7F, 8'h00, 8'h01);  // R2 adc
    runOp(4, 8'h42, 8'h42, 8'h00);  // R7 equal
    runOp(4, 8'h01, 8'h02, 8'h00);  // R7 less
    runOp(5, 8'hFF, 8'h00, 8'h01);  // R8 keep CY=1
    runOp(6, 8'h00, 8'h00, 8'h00);  // R8 keep CY=0
    runOp(6, 8'h10, 8'h00, 8'h01);  // R6 dec nibble
    runOp(7, 8'hF0, 8'h0F, 8'h11);  // R9
    runOp(8, 8'h00, 8'h00, 8'h01);  // R9 zero
    runOp(9, 8'hAA, 8'h55, 8'h11);  // R9
    runOp(10, 8'h81, 8'h00, 8'h00); // R10
    runOp(11, 8'h01, 8'h00, 8'hD4); // R10
    runOp(12, 8'h80, 8'h00, 8'h01); // R10 through carry
    runOp(12, 8'h00, 8'h00, 8'h01);
    runOp(13, 8'h01, 8'h00, 8'h00);
    runOp(13, 8'h00, 8'h00, 8'h01);
    runOp(14, 8'h12, 8'h34, 8'hFF); // R12
    runOp(15, 8'h12, 8'h34, 8'h00); // R12
    // idle hold: R1
    @(negedge clk);
    check("R1", "idle we", accWe, 0);
    check("R1", "idle result hold", resOut, lastRes);
    check("R1", "idle flag hold", flagOut, lastFlg);
    // constrained random
    void'($urandom(32'd20240611));
    for (int n = 0; n < 2000; n++) begin
      int op; int a; int b; logic [7:0] f;
      op = $urandom_range(0, 15);
      a = $urandom_range(0, 255);
      b = ($urandom_range(0, 3) == 0) ? a : $urandom_range(0, 255);
      f = 8'($urandom_range(0, 255));
      runOp(op, a, b, f);
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check("R1", "idle we", accWe, 0);
        check("R1", "idle result hold", resOut, lastRes);
        check("R1", "idle flag hold", flagOut, lastFlg);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule